// File: doc/BRIEF.md
# Sensor Readout Sync and Window Generator

This block produces the pixel-clock frame timing for a Bayer sensor readout whose active line carries a fixed number of pixel columns (644 by default). Every line opens with a blanking stretch whose length comes from a half-length register (twice its value plus one clocks). The active columns follow. A frame is a programmable number of lines. Its first four lines are dark reference lines and the rest carry image rows. The block drives a line strobe, a frame strobe, a dark-line flag, a pixel-valid strobe, and the running row and column counts. A downstream capture stage uses these to pick out image samples.

All settings arrive as static inputs. The block takes a copy of them during reset and again at each frame wrap, so a setting changed mid-frame never disturbs the frame in flight. A rectangular window limits which pixels are flagged valid. Window sizes below the minimum are raised to the minimum. A power-of-two skip factor then thins the window along both axes in units of whole 2x2 colour quads, so the colour pattern survives.

Top module: `readout_sync_gen`

## Requirements
- R1: Each line starts with 2*blank_half+1 clocks of blanking, followed by ACT_COLS active clocks. During the active stretch col_cnt runs 0, 1, ... ACT_COLS-1, and it reads 0 during blanking.
- R2: A frame lasts last_line+1 lines. row_cnt counts the line in the frame from 0 to last_line. vsync is high for the whole of line 0 and low otherwise.
- R3: Lines 0 to 3 of each frame are dark: dark_line is high on them and pix_valid is never high on them.
- R4: hsync is high exactly during the active stretch of every line. When mask_dark_hs is 1 it stays low throughout the four dark lines.
- R5: pix_valid is high only during the active stretch of an image line, and only where col_cnt lies in [win_col0, win_col0+win_wm1] and the image row (row_cnt-4) lies in [win_row0, win_row0+win_hm1]. The array edge clips the window.
- R6: A win_wm1 below 19 acts as 19 (20 columns), and a win_hm1 below 13 acts as 13 (14 rows).
- R7: skip_mode encoding: 0 keeps every pixel, 1 keeps one quad of every 2, 2 and 3 keep one quad of every 4. The test runs on each axis from the window corner: with offset d, (d/2) mod k must be 0, where k is 1, 2 or 4.
- R8: All settings are captured during reset and at the last clock of each frame only. A change made mid-frame first shows in the next frame.
- R9: While rst_n is low: hsync=0, vsync=1, pix_valid=0, dark_line=1, row_cnt=0 and col_cnt=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blank_half | input | NW | Blanking length is twice this plus one |
| last_line | input | VW | Index of the last line in a frame |
| mask_dark_hs | input | 1 | Hold hsync low on dark lines when 1 |
| win_col0 | input | HW | First window column |
| win_row0 | input | VW | First window image row |
| win_wm1 | input | HW | Window width minus one |
| win_hm1 | input | VW | Window height minus one |
| skip_mode | input | 2 | Quad subsampling factor select |
| hsync | output | 1 | High during the active stretch of a line |
| vsync | output | 1 | High during line 0 of a frame |
| pix_valid | output | 1 | Current pixel lies in the window and survives the skip |
| dark_line | output | 1 | Current line is a dark line |
| row_cnt | output | VW | Line index within the frame |
| col_cnt | output | HW | Active column index |

## Verification
The hardest case to reach from the ports is a setting that changes while a frame is running. The design must ignore the change until the wrap, and the only evidence is a whole-frame count taken on both sides of the boundary. The bench moves the blanking length and the skip mode at a fixed clock inside a measured frame. It checks that this frame keeps the old length and pixel count and that the next frame takes on the new ones. Window clipping at the array edge and raising of undersized windows are reached with a bench-sized array of 40 columns and 22 lines, so whole frames stay short enough to count completely.

// File: rtl/rsg_pkg.sv
// Shared types and helpers for the readout sync generator.
// Assumes window offsets are at least 3 bits wide.
package rsg_pkg;

    typedef enum logic [1:0] {
        SKIP_NONE    = 2'd0,
        SKIP_HALF    = 2'd1,
        SKIP_QUARTER = 2'd2,
        SKIP_QUART_B = 2'd3
    } skip_e;

    // Decide whether the quad holding a pixel survives subsampling.
    // q holds bits [2:1] of the pixel offset from the window corner.
    function automatic logic quad_kept(input logic [1:0] q, input skip_e s);
        logic keep;
        case (s)
            SKIP_NONE: keep = 1'b1;
            SKIP_HALF: keep = ~q[0];
            default:   keep = (q == 2'b00);
        endcase
        return keep;
    endfunction

endpackage

// File: rtl/rsg_cfg_shadow.sv
// Frame-boundary copy of the timing and window settings.
// Captures the inputs during reset and on the load strobe. Window sizes
// below the minimum are raised to it as they are captured.
module rsg_cfg_shadow #(
    parameter int NW    = 8,
    parameter int HW    = 10,
    parameter int VW    = 9,
    parameter int MIN_W = 20,
    parameter int MIN_H = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NW-1:0] in_blank_half,
    input  logic [VW-1:0] in_last_line,
    input  logic          in_mask_dark,
    input  logic [HW-1:0] in_col0,
    input  logic [VW-1:0] in_row0,
    input  logic [HW-1:0] in_wm1,
    input  logic [VW-1:0] in_hm1,
    input  logic [1:0]    in_skip,
    output logic [NW-1:0] sh_blank_half,
    output logic [VW-1:0] sh_last_line,
    output logic          sh_mask_dark,
    output logic [HW-1:0] sh_col0,
    output logic [VW-1:0] sh_row0,
    output logic [HW-1:0] sh_wm1,
    output logic [VW-1:0] sh_hm1,
    output logic [1:0]    sh_skip
);

    localparam logic [HW-1:0] WM1_MIN = HW'(MIN_W - 1);
    localparam logic [VW-1:0] HM1_MIN = VW'(MIN_H - 1);

    logic [HW-1:0] wm1_clamped;
    logic [VW-1:0] hm1_clamped;

    // Raise undersized window extents to the minimum.
    always_comb begin
        wm1_clamped = (in_wm1 < WM1_MIN) ? WM1_MIN : in_wm1;
        hm1_clamped = (in_hm1 < HM1_MIN) ? HM1_MIN : in_hm1;
    end

    // Capture the settings in reset and at each frame wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sh_blank_half <= in_blank_half;
            sh_last_line  <= in_last_line;
            sh_mask_dark  <= in_mask_dark;
            sh_col0       <= in_col0;
            sh_row0       <= in_row0;
            sh_wm1        <= wm1_clamped;
            sh_hm1        <= hm1_clamped;
            sh_skip       <= in_skip;
        end
    end

endmodule

// File: rtl/rsg_line_timer.sv
// Horizontal position counter for one line: a blanking stretch of
// 2*blank_half+1 clocks, then ACT_COLS active clocks.
// Assumes blank_half is stable for the whole line (it comes from the shadow copy).
module rsg_line_timer #(
    parameter int NW       = 8,
    parameter int HW       = 10,
    parameter int ACT_COLS = 644
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] blank_half,
    output logic          active,
    output logic [HW-1:0] col,
    output logic          line_end
);

    localparam int PW = $clog2((2 ** NW) * 2 + ACT_COLS + 1);
    localparam logic [PW-1:0] ACT_M1 = PW'(ACT_COLS - 1);

    logic [PW-1:0] hpos;
    logic [PW-1:0] blank_len;
    logic [PW-1:0] act_off;

    // Derive blanking length and position inside the active stretch.
    always_comb begin
        blank_len = PW'({blank_half, 1'b1});
        act_off   = hpos - blank_len;
        active    = (hpos >= blank_len);
        line_end  = (hpos == blank_len + ACT_M1);
        col       = active ? HW'(act_off) : '0;
    end

    // Advance the position and wrap at the end of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= '0;
        end else if (line_end) begin
            hpos <= '0;
        end else begin
            hpos <= hpos + PW'(1);
        end
    end

endmodule

// File: rtl/rsg_frame_timer.sv
// Line counter within a frame: last_line+1 lines, the first DARK_LINES
// of them dark. Assumes last_line holds for the whole frame.
module rsg_frame_timer #(
    parameter int VW         = 9,
    parameter int DARK_LINES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic [VW-1:0] last_line,
    output logic [VW-1:0] row,
    output logic          frame_end,
    output logic          first_line,
    output logic          dark
);

    localparam logic [VW-1:0] DARK_N = VW'(DARK_LINES);

    // Decode frame position flags from the line counter.
    always_comb begin
        frame_end  = line_end && (row >= last_line);
        first_line = (row == '0);
        dark       = (row < DARK_N);
    end

    // Step the line counter at each line end and wrap after the last line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
        end else if (frame_end) begin
            row <= '0;
        end else if (line_end) begin
            row <= row + VW'(1);
        end
    end

endmodule

// File: rtl/rsg_window_gate.sv
// Pixel-valid decision: window test on both axes, then quad subsampling
// counted from the window corner. Assumes HW >= 3 and VW >= 3.
module rsg_window_gate #(
    parameter int HW         = 10,
    parameter int VW         = 9,
    parameter int DARK_LINES = 4
) (
    input  logic          active,
    input  logic          dark,
    input  logic [HW-1:0] col,
    input  logic [VW-1:0] row,
    input  logic [HW-1:0] col0,
    input  logic [VW-1:0] row0,
    input  logic [HW-1:0] wm1,
    input  logic [VW-1:0] hm1,
    input  logic [1:0]    skip,
    output logic          pix_valid
);
    import rsg_pkg::*;

    localparam logic [VW:0] DARK_N = (VW + 1)'(DARK_LINES);

    logic [HW:0] h_off;
    logic [VW:0] v_off;
    logic        in_h;
    logic        in_v;
    logic        keep_h;
    logic        keep_v;

    // Offsets from the window corner; the top bit flags a negative offset.
    always_comb begin
        h_off = {1'b0, col} - {1'b0, col0};
        v_off = {1'b0, row} - DARK_N - {1'b0, row0};
    end

    // Window membership on each axis.
    always_comb begin
        in_h = !h_off[HW] && (h_off[HW-1:0] <= wm1);
        in_v = !v_off[VW] && (v_off[VW-1:0] <= hm1);
    end

    // Quad subsampling on each axis.
    always_comb begin
        keep_h = quad_kept(h_off[2:1], skip_e'(skip));
        keep_v = quad_kept(v_off[2:1], skip_e'(skip));
    end

    // Combine active stretch, image line, window and subsampling.
    always_comb begin
        pix_valid = active && !dark && in_h && in_v && keep_h && keep_v;
    end

endmodule

// File: rtl/readout_sync_gen.sv
// Top of the readout sync and window generator. Ties the setting copy,
// line and frame counters and the window gate together. All settings are
// static inputs sampled at reset and at the frame wrap.
module readout_sync_gen #(
    parameter int ACT_COLS   = 644,
    parameter int DARK_LINES = 4,
    parameter int NW         = 8,
    parameter int HW         = 10,
    parameter int VW         = 9,
    parameter int MIN_W      = 20,
    parameter int MIN_H      = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] blank_half,
    input  logic [VW-1:0] last_line,
    input  logic          mask_dark_hs,
    input  logic [HW-1:0] win_col0,
    input  logic [VW-1:0] win_row0,
    input  logic [HW-1:0] win_wm1,
    input  logic [VW-1:0] win_hm1,
    input  logic [1:0]    skip_mode,
    output logic          hsync,
    output logic          vsync,
    output logic          pix_valid,
    output logic          dark_line,
    output logic [VW-1:0] row_cnt,
    output logic [HW-1:0] col_cnt
);

    logic [NW-1:0] sh_blank_half;
    logic [VW-1:0] sh_last_line;
    logic          sh_mask_dark;
    logic [HW-1:0] sh_col0;
    logic [VW-1:0] sh_row0;
    logic [HW-1:0] sh_wm1;
    logic [VW-1:0] sh_hm1;
    logic [1:0]    sh_skip;
    logic          active;
    logic          line_end;
    logic          frame_end;
    logic          first_line;
    logic          dark;
    logic [HW-1:0] col;
    logic [VW-1:0] row;

    rsg_cfg_shadow #(
        .NW(NW), .HW(HW), .VW(VW), .MIN_W(MIN_W), .MIN_H(MIN_H)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(frame_end),
        .in_blank_half(blank_half), .in_last_line(last_line),
        .in_mask_dark(mask_dark_hs), .in_col0(win_col0),
        .in_row0(win_row0), .in_wm1(win_wm1), .in_hm1(win_hm1),
        .in_skip(skip_mode),
        .sh_blank_half(sh_blank_half), .sh_last_line(sh_last_line),
        .sh_mask_dark(sh_mask_dark), .sh_col0(sh_col0),
        .sh_row0(sh_row0), .sh_wm1(sh_wm1), .sh_hm1(sh_hm1),
        .sh_skip(sh_skip)
    );

    rsg_line_timer #(
        .NW(NW), .HW(HW), .ACT_COLS(ACT_COLS)
    ) u_line (
        .clk(clk), .rst_n(rst_n), .blank_half(sh_blank_half),
        .active(active), .col(col), .line_end(line_end)
    );

    rsg_frame_timer #(
        .VW(VW), .DARK_LINES(DARK_LINES)
    ) u_frame (
        .clk(clk), .rst_n(rst_n), .line_end(line_end),
        .last_line(sh_last_line), .row(row), .frame_end(frame_end),
        .first_line(first_line), .dark(dark)
    );

    rsg_window_gate #(
        .HW(HW), .VW(VW), .DARK_LINES(DARK_LINES)
    ) u_gate (
        .active(active), .dark(dark), .col(col), .row(row),
        .col0(sh_col0), .row0(sh_row0), .wm1(sh_wm1), .hm1(sh_hm1),
        .skip(sh_skip), .pix_valid(pix_valid)
    );

    // Drive the sync strobes and counters from the timing state.
    always_comb begin
        hsync     = active && !(dark && sh_mask_dark);
        vsync     = first_line;
        dark_line = dark;
        row_cnt   = row;
        col_cnt   = col;
    end

endmodule

// File: rtl/rsg_checker.sv
// Port-level protocol checks for readout_sync_gen, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module rsg_checker #(
    parameter int HW = 10,
    parameter int VW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync,
    input logic          vsync,
    input logic          pix_valid,
    input logic          dark_line,
    input logic [VW-1:0] row_cnt,
    input logic [HW-1:0] col_cnt
);

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && col_cnt != '0) |-> (col_cnt == $past(col_cnt) + HW'(1))); // R1

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && col_cnt != '0) |-> $stable(row_cnt)); // R2

    AST_VSYNC_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> (row_cnt == '0)); // R2

    AST_NO_DARK_PIX: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> !dark_line); // R3

    AST_PIX_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> hsync); // R5

endmodule

bind readout_sync_gen rsg_checker #(.HW(HW), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .pix_valid(pix_valid), .dark_line(dark_line),
    .row_cnt(row_cnt), .col_cnt(col_cnt)
);

// File: tb/sim_readout_sync_gen.sv
`timescale 1ns/1ps
// Directed bench: each task sets a configuration, measures whole frames
// at the ports and compares the counts with values derived from the requirements.
module sim_readout_sync_gen;

    localparam int C  = 40;
    localparam int DL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] blank_half = 8'd2;
    logic [8:0] last_line = 9'd21;
    logic       mask_dark_hs = 1'b0;
    logic [9:0] win_col0 = 10'd0;
    logic [8:0] win_row0 = 9'd0;
    logic [9:0] win_wm1 = 10'd643;
    logic [8:0] win_hm1 = 9'd487;
    logic [1:0] skip_mode = 2'd0;
    logic       hsync, vsync, pix_valid, dark_line;
    logic [8:0] row_cnt;
    logic [9:0] col_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    int m_clk, m_vs, m_hsc, m_hsp, m_first, m_width, m_dark, m_pv, m_pvdark;
    int m_cmin, m_cmax, m_rmin, m_rmax;
    logic [7:0] p_blank;
    logic [1:0] p_skip;

    always #2 clk = ~clk;

    readout_sync_gen #(.ACT_COLS(C), .DARK_LINES(DL)) u0 (
        .clk(clk), .rst_n(rst_n), .blank_half(blank_half),
        .last_line(last_line), .mask_dark_hs(mask_dark_hs),
        .win_col0(win_col0), .win_row0(win_row0), .win_wm1(win_wm1),
        .win_hm1(win_hm1), .skip_mode(skip_mode), .hsync(hsync),
        .vsync(vsync), .pix_valid(pix_valid), .dark_line(dark_line),
        .row_cnt(row_cnt), .col_cnt(col_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Kept positions along one axis per R5, R6 and R7.
    function automatic int exp_axis(input int start, input int szm1, input int minm1,
                                    input int extent, input int sk);
        int eff = (szm1 < minm1) ? minm1 : szm1;
        int k = (sk == 0) ? 1 : ((sk == 1) ? 2 : 4);
        int cnt = 0;
        for (int i = 0; i < extent; i++) begin
            int off = i - start;
            if (off >= 0 && off <= eff && ((off / 2) % k) == 0) cnt++;
        end
        return cnt;
    endfunction

    // Wait for a frame start and measure the frame; apply pending settings at chg_at.
    task automatic measure(input int chg_at);
        logic last_vs, last_hs, seen_hs, width_done;
        last_vs = vsync;
        forever begin
            @(negedge clk);
            if (vsync && !last_vs) break;
            last_vs = vsync;
        end
        m_clk = 0; m_vs = 0; m_hsc = 0; m_hsp = 0; m_first = 0; m_width = 0;
        m_dark = 0; m_pv = 0; m_pvdark = 0;
        m_cmin = 9999; m_cmax = -1; m_rmin = 9999; m_rmax = -1;
        last_hs = 1'b0; seen_hs = 1'b0; width_done = 1'b0;
        forever begin
            m_clk++;
            if (vsync) m_vs++;
            if (hsync) m_hsc++;
            if (hsync && !last_hs) m_hsp++;
            if (!seen_hs && !hsync) m_first++;
            if (hsync) seen_hs = 1'b1;
            if (seen_hs && !width_done) begin
                if (hsync) m_width++; else width_done = 1'b1;
            end
            if (dark_line) m_dark++;
            if (pix_valid) begin
                m_pv++;
                if (dark_line) m_pvdark++;
                if (int'(col_cnt) < m_cmin) m_cmin = int'(col_cnt);
                if (int'(col_cnt) > m_cmax) m_cmax = int'(col_cnt);
                if (int'(row_cnt) < m_rmin) m_rmin = int'(row_cnt);
                if (int'(row_cnt) > m_rmax) m_rmax = int'(row_cnt);
            end
            if (chg_at > 0 && m_clk == chg_at) begin
                blank_half = p_blank;
                skip_mode = p_skip;
            end
            last_hs = hsync;
            last_vs = vsync;
            @(negedge clk);
            if (vsync && !last_vs) break;
        end
    endtask

    task automatic set_cfg(input int nb, input int ll, input bit mk, input int c0,
                           input int r0, input int wm, input int hm, input int sk);
        blank_half = 8'(nb); last_line = 9'(ll); mask_dark_hs = mk;
        win_col0 = 10'(c0); win_row0 = 9'(r0); win_wm1 = 10'(wm);
        win_hm1 = 9'(hm); skip_mode = 2'(sk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 hsync", int'(hsync), 0);
        chk("R9 vsync", int'(vsync), 1);
        chk("R9 pix_valid", int'(pix_valid), 0);
        chk("R9 dark_line", int'(dark_line), 1);
        chk("R9 row_cnt", int'(row_cnt), 0);
        chk("R9 col_cnt", int'(col_cnt), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_full_frame();
        set_cfg(2, 21, 0, 0, 0, 643, 487, 0);
        measure(0);
        chk("R1 blank clocks", m_first, 5);
        chk("R1 active width", m_width, C);
        chk("R2 frame clocks", m_clk, 22 * (5 + C));
        chk("R2 vsync clocks", m_vs, 5 + C);
        chk("R2 last row", m_rmax, 21);
        chk("R3 dark clocks", m_dark, DL * (5 + C));
        chk("R3 no dark pixels", m_pvdark, 0);
        chk("R4 hsync pulses", m_hsp, 22);
        chk("R5 full pixels", m_pv, C * 18);
        chk("R5 first row", m_rmin, DL);
    endtask

    task automatic t_mask_dark();
        set_cfg(2, 21, 1, 0, 0, 643, 487, 0);
        measure(0);
        chk("R4 masked pulses", m_hsp, 18);
        chk("R4 masked hsync clocks", m_hsc, 18 * C);
        chk("R4 masked pixels unchanged", m_pv, C * 18);
    endtask

    task automatic t_blank_len();
        set_cfg(7, 11, 0, 0, 0, 643, 487, 0);
        measure(0);
        chk("R1 blank clocks nb7", m_first, 15);
        chk("R2 frame clocks short", m_clk, 12 * (15 + C));
        chk("R3 pixels short frame", m_pv, C * 8);
    endtask

    task automatic t_window();
        set_cfg(2, 21, 0, 5, 2, 21, 13, 0);
        measure(0);
        chk("R5 window pixels", m_pv, 22 * 14);
        chk("R5 window col min", m_cmin, 5);
        chk("R5 window col max", m_cmax, 26);
        chk("R5 window row min", m_rmin, DL + 2);
        chk("R5 window row max", m_rmax, DL + 15);
        set_cfg(2, 21, 0, 30, 10, 21, 13, 0);
        measure(0);
        chk("R5 clipped pixels", m_pv,
            exp_axis(30, 21, 19, C, 0) * exp_axis(10, 13, 13, 18, 0));
        chk("R5 clipped col max", m_cmax, C - 1);
    endtask

    task automatic t_min_size();
        set_cfg(2, 21, 0, 0, 0, 3, 2, 0);
        measure(0);
        chk("R6 raised window pixels", m_pv, 20 * 14);
        chk("R6 raised col max", m_cmax, 19);
    endtask

    task automatic t_skip();
        for (int sk = 1; sk < 4; sk++) begin
            set_cfg(2, 21, 0, 3, 1, 643, 487, sk);
            measure(0);
            chk("R7 skip pixels", m_pv,
                exp_axis(3, 643, 19, C, sk) * exp_axis(1, 487, 13, 18, sk));
            chk("R7 skip first col", m_cmin, 3);
        end
    endtask

    task automatic t_midframe();
        set_cfg(2, 21, 0, 0, 0, 643, 487, 0);
        p_blank = 8'd7;
        p_skip = 2'd1;
        measure(300);
        chk("R8 old frame clocks", m_clk, 22 * (5 + C));
        chk("R8 old frame pixels", m_pv, C * 18);
        measure(0);
        chk("R8 new frame clocks", m_clk, 22 * (15 + C));
        chk("R8 new frame pixels", m_pv,
            exp_axis(0, 643, 19, C, 1) * exp_axis(0, 487, 13, 18, 1));
    endtask

    initial begin
        t_reset();
        t_full_frame();
        t_mask_dark();
        t_blank_len();
        t_window();
        t_min_size();
        t_skip();
        t_midframe();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule